// File: doc/BRIEF.md
# ADC Host Bus Port

This block sits between a host processor bus and the core of an 8-bit analog-to-digital converter. The host selects the device with an active-low select line and uses active-low read and write strobes. A write, completed by the strobe returning high, launches one conversion in the core. A single-cycle start pulse carries the request to the core.

The core answers with a done pulse and an 8-bit code. The port latches that code and pulls its active-low interrupt line down to tell the host that a result is waiting. A read with the device selected enables the output drivers so that the code reaches the shared data bus. The read also clears the interrupt. The three-state driver is modelled as an output-enable plus a data vector, so the block stays synthesizable. The data vector is forced to zero whenever the enable is off.

With the default 8-bit width and a 5 V span, one code step is 5/255 V, about 19.6 mV. The core keeps to that scale and the port never interprets it.

Top module: `adc_host_port`

## Requirements
- R1: After reset, int_n is 1, conv_start is 0, data_oe is 0 and the held result is 0, so a read returns 0.
- R2: When wr_n is sampled low with cs_n low on one clock edge and wr_n is sampled high on the next edge, conv_start is high for exactly one cycle, starting just after that second edge.
- R3: A write strobe given while cs_n is high produces no conv_start.
- R4: If wr_n is held low for many cycles and then released, exactly one conv_start is produced.
- R5: A conv_done that arrives while a conversion is outstanding latches conv_result. int_n then goes to 0 on the same clock edge.
- R6: data_oe is 1 exactly when cs_n and rd_n are both 0, without waiting for a clock. While data_oe is 1, data_out equals the latched result; otherwise data_out is 0.
- R7: A read that is present at a clock edge with cs_n low sets int_n back to 1. A read strobe given while cs_n is high leaves int_n at 0.
- R8: conv_start returns int_n to 1 even when no read has taken place.
- R9: A conv_done that arrives while no conversion is outstanding is ignored. Both int_n and the latched result stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Device select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; conversion launches on its release |
| conv_start | output | 1 | One-cycle request to the converter core |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_result | input | W | Code from the core, valid with conv_done |
| data_out | output | W | Data driven toward the shared bus |
| data_oe | output | 1 | Output-enable of the bus drivers |
| int_n | output | 1 | End-of-conversion interrupt, active low |

## Verification
The assertions assume that the core raises conv_done only as a single-cycle pulse. They also assume that the core never raises it in the same cycle as conv_start, and that the host strobes are synchronous to clk. The bench drives every strobe at the falling clock edge. Its fixed-latency core model answers only some cycles after each start. A stray completion is injected only while no conversion is outstanding, so it never collides with a start.

// File: rtl/adc_host_port.sv
module adc_host_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  output logic         conv_start,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  output logic [W-1:0] data_out,
  output logic         data_oe,
  output logic         int_n
);

  logic         wr_armed;
  logic         busy;
  logic [W-1:0] result_q;

  wire rd_sel = !cs_n && !rd_n;
  wire launch = wr_armed && wr_n;
  wire accept = busy && conv_done;

  assign data_oe  = rd_sel;
  assign data_out = rd_sel ? result_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_armed   <= 1'b0;
      conv_start <= 1'b0;
      busy       <= 1'b0;
      int_n      <= 1'b1;
      result_q   <= '0;
    end else begin
      wr_armed   <= !wr_n && !cs_n;
      conv_start <= launch;
      if (launch) begin
        busy  <= 1'b1;
        int_n <= 1'b1;
      end else if (accept) begin
        busy     <= 1'b0;
        result_q <= conv_result;
        int_n    <= 1'b0;
      end else if (rd_sel) begin
        int_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_host_port_props.sv
module adc_host_port_props #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic         conv_start,
  input logic         conv_done,
  input logic [W-1:0] data_out,
  input logic         data_oe,
  input logic         int_n
);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(wr_n) && !$past(wr_n, 2) && !$past(cs_n, 2)));

  p_bus_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!data_oe && data_out == '0));

  p_int_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(conv_done));

  p_start_clears_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> int_n);

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> ($past(!cs_n && !rd_n) || conv_start));

endmodule

bind adc_host_port adc_host_port_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .conv_start(conv_start), .conv_done(conv_done), .data_out(data_out),
  .data_oe(data_oe), .int_n(int_n)
);

// File: tb/adc_host_port_test.sv
module adc_host_port_test;
  localparam int W = 8;
  localparam int LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic conv_start, data_oe, int_n;
  logic [W-1:0] data_out;
  logic done_m = 1'b0, done_x = 1'b0;
  logic [W-1:0] code_m = '0, code_x = '0;
  int cnt = 0, starts = 0, checks = 0, fails = 0;

  always #2 clk = ~clk;

  adc_host_port #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .conv_start(conv_start), .conv_done(done_m | done_x),
    .conv_result(done_x ? code_x : code_m),
    .data_out(data_out), .data_oe(data_oe), .int_n(int_n)
  );

  always @(posedge clk) begin
    done_m <= 1'b0;
    if (conv_start) begin
      starts <= starts + 1;
      cnt <= LAT;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) done_m <= 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel_n, input int hold);
    @(negedge clk); cs_n = sel_n; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic do_read(input logic sel_n, output logic [W-1:0] val, output logic oe);
    @(negedge clk); cs_n = sel_n; rd_n = 1'b0;
    #1 val = data_out; oe = data_oe;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic oe;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 int_n", int_n, 1);
    check("R1 conv_start", conv_start, 0);
    check("R1 data_oe", data_oe, 0);
    do_read(1'b0, v, oe);
    check("R1 result", v, 0);

    // R6: select high keeps drivers off
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    #1 check("R6 oe with cs high", data_oe, 0);
    check("R6 data with cs high", data_out, 0);
    @(negedge clk); rd_n = 1'b1;

    // R3: unselected write
    s0 = starts;
    do_write(1'b1, 1);
    repeat (LAT + 4) @(negedge clk);
    check("R3 starts", starts - s0, 0);
    check("R3 int_n", int_n, 1);

    // R2 R5 R6 R7 sweep over all codes
    for (int c = 0; c < (1 << W); c++) begin
      code_m = c[W-1:0];
      s0 = starts;
      do_write(1'b0, 1 + (c % 3));
      repeat (LAT + 3) @(negedge clk);
      check("R2 one start", starts - s0, 1);
      check("R5 int_n low", int_n, 0);
      do_read(1'b0, v, oe);
      check("R6 oe", oe, 1);
      check("R6 data", v, c);
      check("R7 cleared", int_n, 1);
    end

    // R4: long hold gives one start
    s0 = starts;
    code_m = 8'h3C;
    do_write(1'b0, 40);
    repeat (LAT + 3) @(negedge clk);
    check("R4 starts", starts - s0, 1);

    // R7: unselected read leaves interrupt pending
    do_read(1'b1, v, oe);
    check("R7 oe", oe, 0);
    check("R7 int kept", int_n, 0);

    // R8: new write releases interrupt before done
    code_m = 8'h81;
    do_write(1'b0, 1);
    check("R8 int_n", int_n, 1);
    repeat (LAT + 3) @(negedge clk);
    check("R8 int back low", int_n, 0);
    do_read(1'b0, v, oe);
    check("R8 data", v, 8'h81);

    // R9: stray done while idle
    @(negedge clk); code_x = 8'hAA; done_x = 1'b1;
    @(negedge clk); done_x = 1'b0;
    @(negedge clk);
    check("R9 int_n", int_n, 1);
    do_read(1'b0, v, oe);
    check("R9 result kept", v, 8'h81);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule